// File: doc/BRIEF.md
# Read-Triggered Multicart Bank Controller

This block is the bank controller of a multi-game cartridge for an 8-bit console. It watches CPU bus cycles in the top ROM area. When the CPU reads from one of three small address windows, the block captures the byte that appears on the data bus during that read. So software picks a bank by reading a ROM location that already holds the wanted value, instead of writing it. Writes are ignored, because on the real bus they would collide with the ROM output.

Three registers hold the captured values:
- **Outer register.** Selects a game block, a ROM pair, the banking mode and the nametable mirroring. It locks itself once any block or pair bit is nonzero. Only a reset clears the lock.
- **Inner register.** Selects the CHR page and, in the second mode, a PRG page. It stays writable at all times.
- **Defeat register.** Drives a two-bit lockout-defeat charge pump.

From these registers the block produces:
- a 32 KiB PRG bank number for CPU $8000-$FFFF,
- an 8 KiB CHR bank number,
- two ROM-pair enables,
- the mirroring select.

The two game modes build the bank numbers differently. Mode 0 has a fixed PRG bank and only the CHR page banked. Mode 1 banks both PRG and CHR.

Top module: `mcart_readlatch_ctrl`

## Requirements
- R1: After reset, all state is zero. The outputs are then: `prg_bank` 0, `chr_bank` 0, `mirror_horiz` 0, `defeat_drive` 0, `rom_pair_lo_en` 1 and `rom_pair_hi_en` 0.
- R2: The outer register loads the full data byte on a clock edge where `cpu_rd` is 1 and `cpu_addr` lies in 0xFF80..0xFF9F. A cycle with `cpu_rd` 0, or with an address outside that window, leaves it unchanged. Its layout is:
  - bit 7: mirroring (1 = horizontal)
  - bit 6: mode
  - bit 5: pair select Q
  - bit 4: high-pair disable q
  - bits 3:0: block field
- R3: A qualified read in 0xFFE8..0xFFF7 loads the inner register. Data bits 6:4 become the CHR page, with bit 6 as its top bit c and bits 5:4 as its low field. Data bit 0 becomes the PRG page P. Addresses 0xFFE7 and 0xFFF8 do not load it.
- R4: A qualified read in 0xFFC0..0xFFDF loads data bits 1:0 into the defeat register, which drives `defeat_drive`.
- R5: While outer bits 5:0 are not all zero, reads of the outer and defeat windows leave both registers unchanged until reset.
- R6: The inner register keeps loading while the outer register is locked.
- R7: In mode 0, `prg_bank` equals the block field, and `chr_bank` is the block field followed by the inner low CHR field.
- R8: In mode 1, `prg_bank` is block bits 3:1 followed by P. `chr_bank` is block bits 3:1 followed by c and the low CHR field.
- R9: `rom_pair_lo_en` is the inverse of Q. `rom_pair_hi_en` is Q AND NOT q, so q forces the high pair off even when Q selects it.
- R10: `mirror_horiz` follows outer bit 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | Data bus byte seen during the cycle |
| cpu_rd | input | 1 | CPU read strobe |
| prg_bank | output | 4 | 32 KiB PRG bank number |
| chr_bank | output | 6 | 8 KiB CHR bank number |
| rom_pair_lo_en | output | 1 | Enable for ROMs 1+2 (active high) |
| rom_pair_hi_en | output | 1 | Enable for ROMs 3+4 (active high) |
| mirror_horiz | output | 1 | Mirroring select, 1 = horizontal |
| defeat_drive | output | 2 | Lockout-defeat pump drive |

## Verification
The assertions assume three things about the inputs:
- `cpu_rd`, `cpu_addr` and `cpu_data` are stable across each rising edge.
- A read lasts exactly one sampled edge.
- Reset is applied before the first qualified read.

The stimulus changes inputs only on falling edges and holds them for one full cycle. It pulses reset often so that the one-shot lock releases and the unlocked paths keep getting exercised. Random outer bytes are frequently masked down to the mirroring and mode bits, so that many reads arrive while the register is still unlocked.

// File: rtl/mcart_pkg.sv
package mcart_pkg;
   typedef enum logic [1:0] {
      WIN_NONE   = 2'd0,
      WIN_OUTER  = 2'd1,
      WIN_DEFEAT = 2'd2,
      WIN_INNER  = 2'd3
   } win_e;
endpackage

// File: rtl/mcart_win_decode.sv
module mcart_win_decode
   import mcart_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter logic [ADDR_W-1:0] OUT_LO = 16'hFF80,
   parameter logic [ADDR_W-1:0] OUT_HI = 16'hFF9F,
   parameter logic [ADDR_W-1:0] DEF_LO = 16'hFFC0,
   parameter logic [ADDR_W-1:0] DEF_HI = 16'hFFDF,
   parameter logic [ADDR_W-1:0] INN_LO = 16'hFFE8,
   parameter logic [ADDR_W-1:0] INN_HI = 16'hFFF7
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              rd_i,
   output win_e              win_o
);
   initial begin
      assert (OUT_LO <= OUT_HI && DEF_LO <= DEF_HI && INN_LO <= INN_HI)
         else $error("window bounds reversed");
   end

   logic qual;
   assign qual = rd_i & addr_i[ADDR_W-1];

   always_comb begin
      win_o = WIN_NONE;
      if (qual) begin
         if (addr_i >= OUT_LO && addr_i <= OUT_HI)      win_o = WIN_OUTER;
         else if (addr_i >= DEF_LO && addr_i <= DEF_HI) win_o = WIN_DEFEAT;
         else if (addr_i >= INN_LO && addr_i <= INN_HI) win_o = WIN_INNER;
      end
   end
endmodule

// File: rtl/mcart_outer_reg.sv
module mcart_outer_reg #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned BLK_W  = 4,
   parameter int unsigned DEF_W  = 2,
   localparam int unsigned LOCK_W = BLK_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_outer_i,
   input  logic              ld_defeat_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [DATA_W-1:0] outer_o,
   output logic [DEF_W-1:0]  defeat_o,
   output logic              locked_o
);
   initial begin
      assert (DATA_W == BLK_W + 4) else $error("outer layout needs BLK_W+4 bits");
      assert (DEF_W <= DATA_W) else $error("defeat field too wide");
   end

   logic [DATA_W-1:0] outer_q;
   logic [DEF_W-1:0]  defeat_q;

   assign locked_o = |outer_q[LOCK_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         outer_q  <= '0;
         defeat_q <= '0;
      end else if (!locked_o) begin
         if (ld_outer_i)  outer_q  <= data_i;
         if (ld_defeat_i) defeat_q <= data_i[DEF_W-1:0];
      end
   end

   assign outer_o  = outer_q;
   assign defeat_o = defeat_q;

   p_outer_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      locked_o |=> $stable(outer_q));
   p_defeat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      locked_o |=> $stable(defeat_q));
   p_outer_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_outer_i && !locked_o) |=> outer_q == $past(data_i));
endmodule

// File: rtl/mcart_inner_reg.sv
module mcart_inner_reg #(
   parameter int unsigned CHR_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_i,
   input  logic [CHR_W-1:0] chr_i,
   input  logic             prg_i,
   output logic [CHR_W-1:0] chr_o,
   output logic             prg_o
);
   initial begin
      assert (CHR_W >= 2) else $error("CHR page needs at least 2 bits");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chr_o <= '0;
         prg_o <= 1'b0;
      end else if (ld_i) begin
         chr_o <= chr_i;
         prg_o <= prg_i;
      end
   end

   p_inner_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ld_i |=> (chr_o == $past(chr_i) && prg_o == $past(prg_i)));
endmodule

// File: rtl/mcart_bank_compose.sv
module mcart_bank_compose #(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned BLK_W      = 4,
   parameter int unsigned CHR_W      = 3,
   parameter bit          EN_ACT_LOW = 1'b0,
   localparam int unsigned CHR_OUT_W = BLK_W + CHR_W - 1
) (
   input  logic [DATA_W-1:0]    outer_i,
   input  logic [CHR_W-1:0]     inner_chr_i,
   input  logic                 inner_prg_i,
   output logic [BLK_W-1:0]     prg_bank_o,
   output logic [CHR_OUT_W-1:0] chr_bank_o,
   output logic                 lo_en_o,
   output logic                 hi_en_o,
   output logic                 mirror_o
);
   logic [BLK_W-1:0] blk;
   logic             dis_q, sel_q, mode;
   logic             lo_act, hi_act;

   assign blk      = outer_i[BLK_W-1:0];
   assign dis_q    = outer_i[BLK_W];
   assign sel_q    = outer_i[BLK_W+1];
   assign mode     = outer_i[BLK_W+2];
   assign mirror_o = outer_i[BLK_W+3];

   always_comb begin
      if (mode) begin
         prg_bank_o = {blk[BLK_W-1:1], inner_prg_i};
         chr_bank_o = {blk[BLK_W-1:1], inner_chr_i};
      end else begin
         prg_bank_o = blk;
         chr_bank_o = {blk, inner_chr_i[CHR_W-2:0]};
      end
   end

   assign lo_act = ~sel_q;
   assign hi_act = sel_q & ~dis_q;

   generate
      if (EN_ACT_LOW) begin : g_en_low
         assign lo_en_o = ~lo_act;
         assign hi_en_o = ~hi_act;
      end else begin : g_en_high
         assign lo_en_o = lo_act;
         assign hi_en_o = hi_act;
      end
   endgenerate
endmodule

// File: rtl/mcart_readlatch_ctrl.sv
module mcart_readlatch_ctrl
   import mcart_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned BLK_W      = 4,
   parameter int unsigned CHR_W      = 3,
   parameter int unsigned DEF_W      = 2,
   parameter bit          EN_ACT_LOW = 1'b0,
   localparam int unsigned CHR_OUT_W = BLK_W + CHR_W - 1,
   localparam int unsigned CHR_LSB   = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    cpu_addr,
   input  logic [DATA_W-1:0]    cpu_data,
   input  logic                 cpu_rd,
   output logic [BLK_W-1:0]     prg_bank,
   output logic [CHR_OUT_W-1:0] chr_bank,
   output logic                 rom_pair_lo_en,
   output logic                 rom_pair_hi_en,
   output logic                 mirror_horiz,
   output logic [DEF_W-1:0]     defeat_drive
);
   initial begin
      assert (CHR_LSB + CHR_W <= DATA_W) else $error("inner CHR field exceeds data width");
      assert (ADDR_W == 16) else $error("window bounds assume 16-bit addresses");
   end

   win_e              win;
   logic [DATA_W-1:0] outer;
   logic [CHR_W-1:0]  in_chr;
   logic              in_prg;
   logic              locked;

   mcart_win_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr_i(cpu_addr), .rd_i(cpu_rd), .win_o(win));

   mcart_outer_reg #(.DATA_W(DATA_W), .BLK_W(BLK_W), .DEF_W(DEF_W)) u_outer (
      .clk(clk), .rst_n(rst_n),
      .ld_outer_i(win == WIN_OUTER), .ld_defeat_i(win == WIN_DEFEAT),
      .data_i(cpu_data), .outer_o(outer), .defeat_o(defeat_drive),
      .locked_o(locked));

   mcart_inner_reg #(.CHR_W(CHR_W)) u_inner (
      .clk(clk), .rst_n(rst_n), .ld_i(win == WIN_INNER),
      .chr_i(cpu_data[CHR_LSB+CHR_W-1:CHR_LSB]), .prg_i(cpu_data[0]),
      .chr_o(in_chr), .prg_o(in_prg));

   mcart_bank_compose #(.DATA_W(DATA_W), .BLK_W(BLK_W), .CHR_W(CHR_W),
                        .EN_ACT_LOW(EN_ACT_LOW)) u_comp (
      .outer_i(outer), .inner_chr_i(in_chr), .inner_prg_i(in_prg),
      .prg_bank_o(prg_bank), .chr_bank_o(chr_bank),
      .lo_en_o(rom_pair_lo_en), .hi_en_o(rom_pair_hi_en),
      .mirror_o(mirror_horiz));

   generate
      if (!EN_ACT_LOW) begin : g_chk
         p_hi_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
            outer[BLK_W] |-> !rom_pair_hi_en);
         p_pair_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0({rom_pair_lo_en, rom_pair_hi_en}));
      end
   endgenerate

   p_mode0_prg_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!outer[BLK_W+2] && !locked) |-> prg_bank == '0);
endmodule

// File: tb/mcart_readlatch_ctrl_tb.sv
module mcart_readlatch_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_data = '0;
   logic        cpu_rd = 1'b0;
   logic [3:0]  prg_bank;
   logic [5:0]  chr_bank;
   logic        rom_pair_lo_en, rom_pair_hi_en, mirror_horiz;
   logic [1:0]  defeat_drive;

   int n_chk = 0;
   int n_bad = 0;

   logic [7:0] m_outer;
   logic [2:0] m_chr;
   logic       m_prg;
   logic [1:0] m_def;

   always #4 clk = ~clk;

   mcart_readlatch_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
      .cpu_rd(cpu_rd), .prg_bank(prg_bank), .chr_bank(chr_bank),
      .rom_pair_lo_en(rom_pair_lo_en), .rom_pair_hi_en(rom_pair_hi_en),
      .mirror_horiz(mirror_horiz), .defeat_drive(defeat_drive));

   function automatic logic [3:0] exp_prg();
      return m_outer[6] ? {m_outer[3:1], m_prg} : m_outer[3:0];
   endfunction
   function automatic logic [5:0] exp_chr();
      return m_outer[6] ? {m_outer[3:1], m_chr} : {m_outer[3:0], m_chr[1:0]};
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      string mreq;
      mreq = m_outer[6] ? "R8" : "R7";
      chk({mreq, " prg ", tag}, prg_bank, exp_prg());
      chk({mreq, " chr ", tag}, chr_bank, exp_chr());
      chk({"R9 lo ", tag}, rom_pair_lo_en, !m_outer[5]);
      chk({"R9 hi ", tag}, rom_pair_hi_en, m_outer[5] & !m_outer[4]);
      chk({"R10 mirror ", tag}, mirror_horiz, m_outer[7]);
      chk({"R4 defeat ", tag}, defeat_drive, m_def);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; cpu_rd = 1'b0;
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      m_outer = '0; m_chr = '0; m_prg = 1'b0; m_def = '0;
      check_all("R1 reset");
   endtask

   task automatic apply(input logic [15:0] a, input logic [7:0] d, input logic rd,
                        input string tag);
      logic locked;
      @(negedge clk);
      cpu_addr = a; cpu_data = d; cpu_rd = rd;
      @(posedge clk);
      locked = |m_outer[5:0];
      if (rd && a[15]) begin
         if (a >= 16'hFF80 && a <= 16'hFF9F && !locked) m_outer = d;
         else if (a >= 16'hFFC0 && a <= 16'hFFDF && !locked) m_def = d[1:0];
         else if (a >= 16'hFFE8 && a <= 16'hFFF7) begin
            m_chr = d[6:4]; m_prg = d[0];
         end
      end
      @(negedge clk);
      cpu_rd = 1'b0;
      check_all(tag);
   endtask

   initial begin
      #1000000;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      do_reset();
      apply(16'hFF80, 8'hC0, 1'b1, "R2 mode/mirror load");
      apply(16'hFF85, 8'h3F, 1'b0, "R2 write ignored");
      apply(16'hFFA0, 8'h3F, 1'b1, "R2 outside window");
      apply(16'hFFC3, 8'h03, 1'b1, "R4 defeat load");
      apply(16'hFFE8, 8'h71, 1'b1, "R3 inner low edge");
      apply(16'hFFE7, 8'h00, 1'b1, "R3 below window");
      apply(16'hFFF8, 8'h00, 1'b1, "R3 above window");
      apply(16'hFF9F, 8'h65, 1'b1, "R2 lock value");
      apply(16'hFF80, 8'h00, 1'b1, "R5 outer locked");
      apply(16'hFFDF, 8'h00, 1'b1, "R5 defeat locked");
      apply(16'hFFF7, 8'h20, 1'b1, "R6 inner while locked");
      do_reset();
      apply(16'hFF90, 8'h30, 1'b1, "R9 q gates high pair");
      do_reset();
      apply(16'hFF90, 8'h20, 1'b1, "R9 high pair on");
      for (int i = 0; i < 3000; i++) begin
         logic [15:0] a;
         logic [7:0]  d;
         int sel;
         if (i % 37 == 36) do_reset();
         sel = $urandom_range(0, 4);
         d = 8'($urandom);
         case (sel)
            0: begin
               a = 16'hFF80 + 16'($urandom_range(0, 31));
               if ($urandom_range(0, 2) != 0) d = d & 8'hC0;
            end
            1: a = 16'hFFC0 + 16'($urandom_range(0, 31));
            2: a = 16'hFFE8 + 16'($urandom_range(0, 15));
            3: a = 16'hFF00 + 16'($urandom_range(0, 255));
            default: a = 16'($urandom);
         endcase
         apply(a, d, $urandom_range(0, 3) != 0, "random R2 R3 R5 R6");
      end
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule